// File: doc/BRIEF.md
# Clock-Stoppable Synchronous Serial Slave

This block is a half-duplex serial slave whose shift logic runs only on the clock that an external master drives onto its clock input. Because neither the receive nor the transmit shifter needs the local system clock, whole words can move while that clock is halted in a low-power state. When a word completes, a combinational request can wake the processor.

A direction input picks the mode. In receive mode the data pad is released, and bits are captured on rising edges of the serial clock, least significant bit first. A finished word is parked in a receive word register and marks the receive-full flag. In transmit mode the pad is driven from the low bit of a shift register that advances on falling serial-clock edges. A holding register is written from the system side and is copied into the shift register at the first falling edge of a word. That frees the holding register and marks transmit-empty again. A receive word that completes while the previous one is unread is dropped, and an overrun flag is raised.

The flags are also brought into the system clock domain through two-flop synchronisers, for software-side use. The wake request itself is formed from the unsynchronised flags. It needs the group enable together with the per-source enable. A separate vector request also requires the global enable, and selects whether the wake enters the service routine or only resumes execution.

Top module: `ssp_slave_wake`

## Requirements
- R1: After reset, rx_full=0, overrun=0, tx_empty=1 and sd_oe=0. With all enables low, wake_o=0 and vector_o=0.
- R2: In receive mode (dir_tx=0), sd_i is sampled on each rising sclk edge, least significant bit first. After the eighth rising edge of a word, rx_data holds the word and rx_full is 1 within three clk cycles.
- R3: A one-cycle rd_stb while rx_full=1 clears rx_full and overrun on the next clk edge.
- R4: A word that completes while the previous word is unread is discarded. rx_data keeps the earlier word and overrun becomes 1 within three clk cycles.
- R5: A wr_stb loads wr_data into the holding register and makes tx_empty 0 on the next clk edge.
- R6: In transmit mode (dir_tx=1), the first falling sclk edge of a word moves a pending held byte into the shift register. sd_o then presents bit 0, and each following falling edge presents the next bit. tx_empty returns to 1 within three clk cycles after that move.
- R7: A byte written while the previous one is shifting is sent in the very next word without any extra sclk edges.
- R8: sd_oe equals dir_tx. In transmit mode, rising sclk edges do not alter rx_full or rx_data.
- R9: wake_o = grp_ie & ((rx_ie & word pending) | (tx_ie & holding register empty)). It follows serial-clock activity with clk stopped.
- R10: vector_o is 1 exactly when wake_o=1 and glb_ie=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, may be stopped |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the external master, idles high |
| sd_i | input | 1 | Serial data pad input |
| sd_o | output | 1 | Serial data pad output value |
| sd_oe | output | 1 | Serial data pad output enable |
| dir_tx | input | 1 | 1 = transmit, 0 = receive |
| rd_stb | input | 1 | Read strobe that unloads the receive word |
| rx_data | output | DATA_W | Last accepted receive word |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to transmit |
| rx_ie | input | 1 | Receive source enable |
| tx_ie | input | 1 | Transmit source enable |
| grp_ie | input | 1 | Peripheral group enable |
| glb_ie | input | 1 | Global enable selecting vectored wake |
| rx_full | output | 1 | Receive word pending (clk domain) |
| overrun | output | 1 | Word dropped while pending (clk domain) |
| tx_empty | output | 1 | Holding register free (clk domain) |
| wake_o | output | 1 | Combinational wake request |
| vector_o | output | 1 | Wake request that should vector |

## Verification
The hardest case to reach is a word completing while the system clock is frozen. At that moment no synchronised flag can move, and only the combinational wake path can respond. The bench gates its own clk off, clocks a full word in or out on sclk, and checks wake_o and vector_o under both settings of the global enable. It then restarts clk and checks that the synchronised flags and rx_data catch up. Overrun is reached by sending two words without a read strobe between them.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int unsigned SSP_WORD_W = 8;
  typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} ssp_dir_e;
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ssp_rx_shift.sv
module ssp_rx_shift #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CW = $clog2(DATA_W)
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sd_i,
  input  logic              full_raw,
  input  logic              ovr_raw,
  output logic [DATA_W-1:0] word_q,
  output logic              set_tog_q,
  output logic              ovr_tog_q
);
  logic [DATA_W-1:0] rsr_q, rsr_d, word_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              set_tog_d, ovr_tog_d, last;

  assign last = (cnt_q == CW'(DATA_W-1));

  always_comb begin
    rsr_d     = rsr_q;
    cnt_d     = cnt_q;
    word_d    = word_q;
    set_tog_d = set_tog_q;
    ovr_tog_d = ovr_tog_q;
    if (en) begin
      rsr_d = {sd_i, rsr_q[DATA_W-1:1]};
      cnt_d = last ? '0 : cnt_q + CW'(1);
      if (last) begin
        if (full_raw) begin
          if (!ovr_raw) ovr_tog_d = ~ovr_tog_q;
        end else begin
          word_d    = rsr_d;
          set_tog_d = ~set_tog_q;
        end
      end
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      rsr_q     <= '0;
      cnt_q     <= '0;
      word_q    <= '0;
      set_tog_q <= 1'b0;
      ovr_tog_q <= 1'b0;
    end else begin
      rsr_q     <= rsr_d;
      cnt_q     <= cnt_d;
      word_q    <= word_d;
      set_tog_q <= set_tog_d;
      ovr_tog_q <= ovr_tog_d;
    end
  end
endmodule

// File: rtl/ssp_tx_shift.sv
module ssp_tx_shift #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CW = $clog2(DATA_W)
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] hold,
  input  logic              pending,
  output logic              sd_o,
  output logic              take_tog_q
);
  logic [DATA_W-1:0] tsr_q, tsr_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              take_tog_d, last;

  assign last = (cnt_q == CW'(DATA_W-1));

  always_comb begin
    tsr_d      = tsr_q;
    cnt_d      = cnt_q;
    take_tog_d = take_tog_q;
    if (en) begin
      if (cnt_q == '0) begin
        if (pending) begin
          tsr_d      = hold;
          cnt_d      = CW'(1);
          take_tog_d = ~take_tog_q;
        end
      end else begin
        tsr_d = tsr_q >> 1;
        cnt_d = last ? '0 : cnt_q + CW'(1);
      end
    end
  end

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      tsr_q      <= '0;
      cnt_q      <= '0;
      take_tog_q <= 1'b0;
    end else begin
      tsr_q      <= tsr_d;
      cnt_q      <= cnt_d;
      take_tog_q <= take_tog_d;
    end
  end

  assign sd_o = tsr_q[0];
endmodule

// File: rtl/ssp_slave_wake.sv
module ssp_slave_wake
  import ssp_pkg::*;
#(
  parameter int unsigned DATA_W      = SSP_WORD_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sd_i,
  output logic              sd_o,
  output logic              sd_oe,
  input  logic              dir_tx,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rx_data,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rx_ie,
  input  logic              tx_ie,
  input  logic              grp_ie,
  input  logic              glb_ie,
  output logic              rx_full,
  output logic              overrun,
  output logic              tx_empty,
  output logic              wake_o,
  output logic              vector_o
);
  ssp_dir_e dir;
  logic [1:0] rst_q;
  logic       rst_s;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic rx_clr_q, rx_clr_d, ovr_clr_q, ovr_clr_d, wr_tog_q, wr_tog_d;
  logic rx_set_tog, ovr_set_tog, take_tog;
  logic rx_set_s, ovr_set_s, take_s;
  logic rx_full_raw, ovr_raw, tx_empty_raw;

  assign dir = ssp_dir_e'(dir_tx);

  // reset: asserted asynchronously, released on clk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s = rst_q[1];

  // flags in raw form (cross-domain compare, valid with clk stopped)
  assign rx_full_raw  = rx_set_tog ^ rx_clr_q;
  assign ovr_raw      = ovr_set_tog ^ ovr_clr_q;
  assign tx_empty_raw = ~(wr_tog_q ^ take_tog);

  ssp_rx_shift #(.DATA_W(DATA_W)) u_rx (
    .sclk(sclk), .rst_n(rst_n), .en(dir == DIR_RX), .sd_i(sd_i),
    .full_raw(rx_full_raw), .ovr_raw(ovr_raw), .word_q(rx_data),
    .set_tog_q(rx_set_tog), .ovr_tog_q(ovr_set_tog)
  );

  ssp_tx_shift #(.DATA_W(DATA_W)) u_tx (
    .sclk(sclk), .rst_n(rst_n), .en(dir == DIR_TX), .hold(hold_q),
    .pending(~tx_empty_raw), .sd_o(sd_o), .take_tog_q(take_tog)
  );

  ssp_sync #(.STAGES(SYNC_STAGES)) u_sync_rx  (.clk(clk), .rst_n(rst_s), .d(rx_set_tog),  .q(rx_set_s));
  ssp_sync #(.STAGES(SYNC_STAGES)) u_sync_ovr (.clk(clk), .rst_n(rst_s), .d(ovr_set_tog), .q(ovr_set_s));
  ssp_sync #(.STAGES(SYNC_STAGES)) u_sync_tx  (.clk(clk), .rst_n(rst_s), .d(take_tog),    .q(take_s));

  assign rx_full  = rx_set_s ^ rx_clr_q;
  assign overrun  = ovr_set_s ^ ovr_clr_q;
  assign tx_empty = ~(wr_tog_q ^ take_s);

  // system-side next state
  always_comb begin
    hold_d    = hold_q;
    wr_tog_d  = wr_tog_q;
    rx_clr_d  = rx_clr_q;
    ovr_clr_d = ovr_clr_q;
    if (wr_stb) begin
      hold_d   = wr_data;
      wr_tog_d = ~wr_tog_q;
    end
    if (rd_stb && rx_full) begin
      rx_clr_d = ~rx_clr_q;
      if (overrun) ovr_clr_d = ~ovr_clr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      hold_q    <= '0;
      wr_tog_q  <= 1'b0;
      rx_clr_q  <= 1'b0;
      ovr_clr_q <= 1'b0;
    end else begin
      hold_q    <= hold_d;
      wr_tog_q  <= wr_tog_d;
      rx_clr_q  <= rx_clr_d;
      ovr_clr_q <= ovr_clr_d;
    end
  end

  assign sd_oe    = (dir == DIR_TX);
  assign wake_o   = grp_ie & ((rx_ie & rx_full_raw) | (tx_ie & tx_empty_raw));
  assign vector_o = wake_o & glb_ie;
endmodule

// File: rtl/ssp_slave_wake_chk.sv
module ssp_slave_wake_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_stb,
  input logic              wr_stb,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_ie,
  input logic              grp_ie,
  input logic              rx_full,
  input logic              overrun,
  input logic              tx_empty,
  input logic              wake_o
);
  p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rx_full) |=> !rx_full);

  p_write_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !tx_empty);

  p_ovr_while_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> rx_full);

  p_data_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && $past(rx_full) && !$past(rd_stb)) |-> $stable(rx_data));

  p_wake_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_ie && rx_ie && rx_full) |-> wake_o);
endmodule

bind ssp_slave_wake ssp_slave_wake_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
  .rx_data(rx_data), .rx_ie(rx_ie), .grp_ie(grp_ie), .rx_full(rx_full),
  .overrun(overrun), .tx_empty(tx_empty), .wake_o(wake_o)
);

// File: tb/ssp_slave_wake_tb.sv
`timescale 1ns/1ps
module ssp_slave_wake_tb;
  localparam int W = 8;
  logic clk = 1'b0, clk_run = 1'b1, rst_n = 1'b0;
  logic sclk = 1'b1, sd_i = 1'b0, dir_tx = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic rx_ie = 0, tx_ie = 0, grp_ie = 0, glb_ie = 0;
  logic sd_o, sd_oe, rx_full, overrun, tx_empty, wake_o, vector_o;
  logic [W-1:0] rx_data, got;
  int checks = 0, fails = 0;

  always #5 clk = clk_run ? ~clk : clk;

  ssp_slave_wake u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sd_i(sd_i), .sd_o(sd_o), .sd_oe(sd_oe),
    .dir_tx(dir_tx), .rd_stb(rd_stb), .rx_data(rx_data), .wr_stb(wr_stb),
    .wr_data(wr_data), .rx_ie(rx_ie), .tx_ie(tx_ie), .grp_ie(grp_ie), .glb_ie(glb_ie),
    .rx_full(rx_full), .overrun(overrun), .tx_empty(tx_empty),
    .wake_o(wake_o), .vector_o(vector_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // master word: falling edge drives, rising edge samples, LSB first
  task automatic xfer(input logic [W-1:0] mosi, output logic [W-1:0] miso);
    for (int i = 0; i < W; i++) begin
      sclk = 1'b0; sd_i = mosi[i];
      #20; miso[i] = sd_o;
      sclk = 1'b1;
      #20;
    end
  endtask

  task automatic settle(); repeat (4) @(negedge clk); endtask

  task automatic rd();
    @(negedge clk); rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0;
  endtask

  task automatic wr(input logic [W-1:0] v);
    @(negedge clk); wr_data = v; wr_stb = 1'b1; @(negedge clk); wr_stb = 1'b0;
  endtask

  initial begin
    #1_500_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1 reset state
    chk(rx_full == 0 && overrun == 0, "R1 rx flags", {rx_full, overrun}, 0);
    chk(tx_empty == 1 && sd_oe == 0, "R1 tx flags", {tx_empty, sd_oe}, 2);
    chk(wake_o == 0 && vector_o == 0, "R1 wake", {wake_o, vector_o}, 0);

    // R2/R3 exhaustive receive sweep
    for (int v = 0; v < 256; v++) begin
      xfer(W'(v), got);
      settle();
      chk(rx_full == 1, "R2 full", rx_full, 1);
      chk(rx_data == W'(v), "R2 data", rx_data, v);
      rd();
      chk(rx_full == 0, "R3 cleared", rx_full, 0);
    end

    // R4 overrun
    xfer(8'h3C, got); xfer(8'hA5, got); settle();
    chk(overrun == 1, "R4 overrun", overrun, 1);
    chk(rx_data == 8'h3C, "R4 data kept", rx_data, 8'h3C);
    rd();
    chk(overrun == 0 && rx_full == 0, "R3 overrun cleared", {overrun, rx_full}, 0);

    // R9/R10 receive wake with clk stopped
    rx_ie = 1; grp_ie = 1; glb_ie = 0;
    #1;
    chk(wake_o == 0, "R9 no wake idle", wake_o, 0);
    @(negedge clk); clk_run = 0;
    xfer(8'h5A, got); #5;
    chk(wake_o == 1, "R9 wake clk stopped", wake_o, 1);
    chk(vector_o == 0, "R10 no vector", vector_o, 0);
    glb_ie = 1; #1;
    chk(vector_o == 1, "R10 vector", vector_o, 1);
    grp_ie = 0; #1;
    chk(wake_o == 0, "R9 group gate", wake_o, 0);
    grp_ie = 1;
    clk_run = 1; settle();
    chk(rx_full == 1 && rx_data == 8'h5A, "R2 after restart", rx_data, 8'h5A);
    rd(); #1;
    chk(wake_o == 0, "R9 wake drops", wake_o, 0);
    rx_ie = 0; glb_ie = 0;

    // R8 transmit mode ignores received bits
    dir_tx = 1; #1;
    chk(sd_oe == 1, "R8 oe tx", sd_oe, 1);
    xfer(8'hFF, got); settle();
    chk(rx_full == 0, "R8 no rx in tx", rx_full, 0);

    // R5/R6 exhaustive transmit sweep
    for (int v = 0; v < 256; v++) begin
      wr(W'(v));
      chk(tx_empty == 0, "R5 write clears", tx_empty, 0);
      xfer('0, got); settle();
      chk(got == W'(v), "R6 shifted", got, v);
      chk(tx_empty == 1, "R6 empty again", tx_empty, 1);
    end

    // R7 back-to-back: second byte written mid-word
    wr(8'hC3);
    sclk = 0; #20; got[0] = sd_o; sclk = 1; #20;
    settle();
    wr(8'h69);
    for (int i = 1; i < W; i++) begin
      sclk = 0; #20; got[i] = sd_o; sclk = 1; #20;
    end
    chk(got == 8'hC3, "R7 first", got, 8'hC3);
    chk(tx_empty == 0, "R7 second pending", tx_empty, 0);
    xfer('0, got);
    chk(got == 8'h69, "R7 second", got, 8'h69);

    // R9 transmit wake with clk stopped
    wr(8'h11);
    tx_ie = 1; grp_ie = 1; #1;
    chk(wake_o == 0, "R9 tx not empty", wake_o, 0);
    @(negedge clk); clk_run = 0;
    sclk = 0; #20; sclk = 1; #20;
    chk(wake_o == 1, "R9 tx wake", wake_o, 1);
    clk_run = 1;
    for (int i = 1; i < W; i++) begin sclk = 0; #20; sclk = 1; #20; end
    settle();
    chk(tx_empty == 1, "R6 empty after", tx_empty, 1);
    dir_tx = 0; #1;
    chk(sd_oe == 0, "R8 oe rx", sd_oe, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule